// File: doc/BRIEF.md
# Credit-Based End-to-End Flow Control Unit

This block sits in a network interface and controls the flow of words for a few unidirectional connections, each paired with a connection running the other way. On the sending side, each connection keeps a count of the free words in the receive buffer at the far end. A word from the local IP is injected into the network only while that count is nonzero, so the network never holds more than the destination can absorb. On the receiving side, each connection owns a private receive FIFO. Every word the local IP drains from it becomes one credit owed to the far sender.

Owed credits travel back in the header of any outgoing data packet on the same connection index. When no such packet is available, a short credit-only packet is sent. This happens either once half a buffer's worth of credits has built up, or once credits have waited for a fixed number of cycles. Before a request word is sent, the block also checks that the matching local receive buffer has room for the whole response. That room is then held back, and the held space is released word by word as words arrive.

Every packet is a single flit that carries a connection index, a data flag, a data word and a credit field. The network between two such units is assumed to be lossless and in order.

Top module: `e2e_credit_ni`

## Requirements
- R1: A word on connection i is accepted (`tx_ready[i]` high) only when that connection's remote-space count is nonzero. With no credits returned, exactly DEPTH words per connection are accepted after reset, and after that `tx_ready` stays low while `tx_valid` is high.
- R2: After reset every remote-space count equals DEPTH, no credits are pending, `nout_valid` is 0 and every `rx_valid` bit is 0.
- R3: Each connection has its own receive FIFO of DEPTH words. Words are delivered on `rx_data` in arrival order, and a FIFO is never written while it holds DEPTH words.
- R4: Each word drained (`rx_pop[i]` while `rx_valid[i]`) adds exactly one pending credit for connection i.
- R5: Credits arriving on `nin_credit` add to the remote space of connection `nin_conn`, capped at DEPTH. After all words are drained and credits have come home, the full space is available again.
- R6: A data packet (`nout_has_data` = 1) sent on connection i carries that connection's pending credits in `nout_credit`, up to 2^CRW-1. Any remainder stays pending.
- R7: When a connection's pending credits reach DEPTH/2 and it has no data ready to send, a credit-only packet (`nout_valid` = 1, `nout_has_data` = 0) carrying them is sent on the next cycle.
- R8: When pending credits stay nonzero for TMO cycles without being sent, a credit-only packet carrying them goes out on the following cycle.
- R9: A word with `tx_is_req[i]` set is accepted only if the occupancy of receive FIFO i, plus its held response space, plus `tx_rsp_len[i]` does not exceed DEPTH. Acceptance adds `tx_rsp_len[i]` to the held space, and each word arriving into FIFO i releases one held word.
- R10: A credit-only packet never carries zero credits. A due credit-only packet is sent before data on any other connection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | NCONN | Per-connection word offered by the local IP |
| tx_data | input | NCONN*W | Offered words, connection i in bits [i*W +: W] |
| tx_is_req | input | NCONN | Offered word is a request that needs response space |
| tx_rsp_len | input | NCONN*CW | Expected response length in words, CW = clog2(DEPTH+1) |
| tx_ready | output | NCONN | Word on connection i is taken this cycle |
| rx_valid | output | NCONN | Receive FIFO i is not empty |
| rx_data | output | NCONN*W | Head word of each receive FIFO |
| rx_pop | input | NCONN | Local IP drains the head word of FIFO i |
| nout_valid | output | 1 | Outgoing flit valid |
| nout_conn | output | CIW | Outgoing connection index |
| nout_has_data | output | 1 | 1: data packet, 0: credit-only packet |
| nout_data | output | W | Outgoing data word |
| nout_credit | output | CRW | Credits returned for the paired connection |
| nin_valid | input | 1 | Incoming flit valid |
| nin_conn | input | CIW | Incoming connection index |
| nin_has_data | input | 1 | Incoming flit carries a data word |
| nin_data | input | W | Incoming data word |
| nin_credit | input | CRW | Incoming returned credits |

## Verification
The assertions rely on the network side behaving as a lossless, in-order channel. They also rely on the credits arriving on `nin_credit` being exactly those the far end earned by draining its FIFO. If either fails, FIFO overflow and the space bound cannot be promised. The stimulus keeps within this assumption by feeding `nout_*` back into `nin_*` through a fixed delay line, so the unit is its own far end. `tx_valid` and `tx_is_req` are held steady from one clock edge to the next, and drains are only requested at times when the bench scoreboard says words are present.

// File: rtl/e2e_fc_pkg.sv
package e2e_fc_pkg;

  typedef enum logic [1:0] {
    PKT_NONE = 2'd0,
    PKT_DATA = 2'd1,
    PKT_CRED = 2'd2
  } pkt_kind_e;

  // width of a counter that must hold 0..depth
  function automatic int cnt_w(input int depth);
    return $clog2(depth + 1);
  endfunction

  // width of the remote-space arithmetic, wide enough for a full credit field
  function automatic int space_w(input int depth, input int crw);
    int c;
    c = $clog2(depth + 1);
    return ((c > crw) ? c : crw) + 1;
  endfunction

endpackage

// File: rtl/e2e_fc_rx_fifo.sv
module e2e_fc_rx_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 wr_en,
  input  logic [W-1:0]                         wr_data,
  input  logic                                 rd_en,
  output logic [W-1:0]                         rd_data,
  output logic [e2e_fc_pkg::cnt_w(DEPTH)-1:0]  occ
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = e2e_fc_pkg::cnt_w(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (wr_en) wr_ptr <= adv(wr_ptr);
      if (rd_en) rd_ptr <= adv(rd_ptr);
      occ <= occ + CW'(wr_en) - CW'(rd_en);
    end
  end

  assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/e2e_fc_credit_acc.sv
module e2e_fc_credit_acc #(
  parameter int DEPTH = 8,
  parameter int CRW   = 5,
  parameter int TMO   = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           drain,
  input  logic           send,
  output logic           due,
  output logic [CRW-1:0] amt
);
  localparam int CW   = e2e_fc_pkg::cnt_w(DEPTH);
  localparam int TW   = $clog2(TMO + 1);
  localparam int HALF = (DEPTH / 2 > 0) ? DEPTH / 2 : 1;
  localparam int CMAX = (1 << CRW) - 1;

  logic [CW-1:0] pend;
  logic [TW-1:0] tmr;

  // field saturates; the remainder stays pending
  assign amt = (int'(pend) > CMAX) ? CRW'(CMAX) : CRW'(pend);
  assign due = (pend != '0) && ((pend >= CW'(HALF)) || (tmr == TW'(TMO)));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      tmr  <= '0;
    end else begin
      pend <= pend - CW'(send ? amt : '0) + CW'(drain);
      if (pend == '0 || send) tmr <= '0;
      else if (tmr != TW'(TMO)) tmr <= tmr + 1'b1;
    end
  end

endmodule

// File: rtl/e2e_fc_space.sv
module e2e_fc_space #(
  parameter int DEPTH = 8,
  parameter int CRW   = 5
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic                                        inject,
  input  logic                                        req_take,
  input  logic [e2e_fc_pkg::cnt_w(DEPTH)-1:0]         req_len,
  input  logic                                        cred_en,
  input  logic [CRW-1:0]                              cred_amt,
  input  logic                                        arrive,
  input  logic [e2e_fc_pkg::cnt_w(DEPTH)-1:0]         occ,
  output logic [e2e_fc_pkg::space_w(DEPTH, CRW)-1:0]  space,
  output logic [e2e_fc_pkg::cnt_w(DEPTH)-1:0]         rsv,
  output logic                                        req_ok
);
  localparam int CW  = e2e_fc_pkg::cnt_w(DEPTH);
  localparam int SW  = e2e_fc_pkg::space_w(DEPTH, CRW);
  localparam int SW1 = SW + 1;
  localparam int RW  = CW + 2;

  logic [SW1-1:0] sum;

  assign sum = {1'b0, space} - SW1'(inject) + SW1'(cred_en ? cred_amt : '0);
  assign req_ok = (RW'(occ) + RW'(rsv) + RW'(req_len)) <= RW'(DEPTH);

  always_ff @(posedge clk) begin
    if (rst) begin
      space <= SW'(DEPTH);
      rsv   <= '0;
    end else begin
      space <= (sum > SW1'(DEPTH)) ? SW'(DEPTH) : sum[SW-1:0];
      rsv   <= rsv + (req_take ? req_len : '0) - CW'(arrive && (rsv != '0));
    end
  end

endmodule

// File: rtl/e2e_credit_ni.sv
module e2e_credit_ni #(
  parameter int NCONN = 2,
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int CRW   = 5,
  parameter int TMO   = 16
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic [NCONN-1:0]                            tx_valid,
  input  logic [NCONN*W-1:0]                          tx_data,
  input  logic [NCONN-1:0]                            tx_is_req,
  input  logic [NCONN*e2e_fc_pkg::cnt_w(DEPTH)-1:0]   tx_rsp_len,
  output logic [NCONN-1:0]                            tx_ready,
  output logic [NCONN-1:0]                            rx_valid,
  output logic [NCONN*W-1:0]                          rx_data,
  input  logic [NCONN-1:0]                            rx_pop,
  output logic                                        nout_valid,
  output logic [((NCONN > 1) ? $clog2(NCONN) : 1)-1:0] nout_conn,
  output logic                                        nout_has_data,
  output logic [W-1:0]                                nout_data,
  output logic [CRW-1:0]                              nout_credit,
  input  logic                                        nin_valid,
  input  logic [((NCONN > 1) ? $clog2(NCONN) : 1)-1:0] nin_conn,
  input  logic                                        nin_has_data,
  input  logic [W-1:0]                                nin_data,
  input  logic [CRW-1:0]                              nin_credit
);
  import e2e_fc_pkg::*;

  localparam int CW  = cnt_w(DEPTH);
  localparam int SW  = space_w(DEPTH, CRW);
  localparam int CIW = (NCONN > 1) ? $clog2(NCONN) : 1;

  logic [NCONN-1:0]       inject, wr, drain, due, can_data, send, req_ok;
  logic [NCONN*CW-1:0]    occ_flat, rsv_flat;
  logic [NCONN*SW-1:0]    space_flat;
  logic [CRW-1:0]         amt_a [NCONN];
  pkt_kind_e              kind;
  logic [CIW-1:0]         sel;

  for (genvar i = 0; i < NCONN; i++) begin : gen_conn
    logic hit;
    assign hit      = nin_valid && (nin_conn == CIW'(i));
    assign wr[i]    = hit && nin_has_data;
    assign rx_valid[i] = occ_flat[i*CW +: CW] != '0;
    assign drain[i] = rx_pop[i] && rx_valid[i];
    assign inject[i] = tx_valid[i] && tx_ready[i];
    assign can_data[i] = tx_valid[i] && (space_flat[i*SW +: SW] != '0) &&
                         (!tx_is_req[i] || req_ok[i]);

    e2e_fc_rx_fifo #(.W(W), .DEPTH(DEPTH)) fifo_i (
      .clk(clk), .rst(rst),
      .wr_en(wr[i]), .wr_data(nin_data),
      .rd_en(drain[i]), .rd_data(rx_data[i*W +: W]),
      .occ(occ_flat[i*CW +: CW])
    );

    e2e_fc_credit_acc #(.DEPTH(DEPTH), .CRW(CRW), .TMO(TMO)) acc_i (
      .clk(clk), .rst(rst),
      .drain(drain[i]), .send(send[i]),
      .due(due[i]), .amt(amt_a[i])
    );

    e2e_fc_space #(.DEPTH(DEPTH), .CRW(CRW)) space_i (
      .clk(clk), .rst(rst),
      .inject(inject[i]),
      .req_take(inject[i] && tx_is_req[i]),
      .req_len(tx_rsp_len[i*CW +: CW]),
      .cred_en(hit), .cred_amt(nin_credit),
      .arrive(wr[i]),
      .occ(occ_flat[i*CW +: CW]),
      .space(space_flat[i*SW +: SW]),
      .rsv(rsv_flat[i*CW +: CW]),
      .req_ok(req_ok[i])
    );
  end

  // a due credit-only flit wins unless its own connection can piggyback
  always_comb begin
    kind = PKT_NONE;
    sel  = '0;
    for (int i = 0; i < NCONN; i++) begin
      if (kind == PKT_NONE && due[i] && !can_data[i]) begin
        kind = PKT_CRED;
        sel  = CIW'(i);
      end
    end
    for (int i = 0; i < NCONN; i++) begin
      if (kind == PKT_NONE && can_data[i]) begin
        kind = PKT_DATA;
        sel  = CIW'(i);
      end
    end
    for (int i = 0; i < NCONN; i++) begin
      tx_ready[i] = (kind == PKT_DATA) && (sel == CIW'(i));
      send[i]     = (kind != PKT_NONE) && (sel == CIW'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nout_valid    <= 1'b0;
      nout_conn     <= '0;
      nout_has_data <= 1'b0;
      nout_data     <= '0;
      nout_credit   <= '0;
    end else begin
      nout_valid    <= kind != PKT_NONE;
      nout_conn     <= sel;
      nout_has_data <= kind == PKT_DATA;
      nout_data     <= (kind == PKT_DATA) ? tx_data[int'(sel)*W +: W] : '0;
      nout_credit   <= (kind != PKT_NONE) ? amt_a[sel] : '0;
    end
  end

endmodule

// File: rtl/e2e_credit_ni_chk.sv
module e2e_credit_ni_chk #(
  parameter int NCONN = 2,
  parameter int DEPTH = 8,
  parameter int CRW   = 5
) (
  input logic                                        clk,
  input logic                                        rst,
  input logic [NCONN-1:0]                            inject,
  input logic [NCONN-1:0]                            wr,
  input logic [NCONN-1:0]                            is_req,
  input logic [NCONN*e2e_fc_pkg::cnt_w(DEPTH)-1:0]   rsp_len,
  input logic [NCONN*e2e_fc_pkg::cnt_w(DEPTH)-1:0]   occ_flat,
  input logic [NCONN*e2e_fc_pkg::cnt_w(DEPTH)-1:0]   rsv_flat,
  input logic [NCONN*e2e_fc_pkg::space_w(DEPTH, CRW)-1:0] space_flat,
  input logic                                        nout_valid,
  input logic                                        nout_has_data,
  input logic [CRW-1:0]                              nout_credit
);
  localparam int CW = e2e_fc_pkg::cnt_w(DEPTH);
  localparam int SW = e2e_fc_pkg::space_w(DEPTH, CRW);

  for (genvar i = 0; i < NCONN; i++) begin : gen_chk
    logic [SW-1:0] sp;
    logic [CW-1:0] oc, rv, ln;
    assign sp = space_flat[i*SW +: SW];
    assign oc = occ_flat[i*CW +: CW];
    assign rv = rsv_flat[i*CW +: CW];
    assign ln = rsp_len[i*CW +: CW];

    p_inject_space_r1: assert property (@(posedge clk) disable iff (rst)
      inject[i] |-> sp != '0)
      else $error("R1 word injected with no remote space");

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
      wr[i] |-> oc < CW'(DEPTH))
      else $error("R3 receive FIFO written while full");

    p_space_bound_r5: assert property (@(posedge clk) disable iff (rst)
      sp <= SW'(DEPTH))
      else $error("R5 remote space above buffer depth");

    p_rsp_room_r9: assert property (@(posedge clk) disable iff (rst)
      (inject[i] && is_req[i]) |-> (int'(oc) + int'(rv) + int'(ln)) <= DEPTH)
      else $error("R9 request issued without response room");
  end

  p_cred_nonzero_r10: assert property (@(posedge clk) disable iff (rst)
    (nout_valid && !nout_has_data) |-> nout_credit != '0)
    else $error("R10 empty credit-only flit");

endmodule

bind e2e_credit_ni e2e_credit_ni_chk #(.NCONN(NCONN), .DEPTH(DEPTH), .CRW(CRW)) chk_i (
  .clk(clk), .rst(rst),
  .inject(inject), .wr(wr), .is_req(tx_is_req), .rsp_len(tx_rsp_len),
  .occ_flat(occ_flat), .rsv_flat(rsv_flat), .space_flat(space_flat),
  .nout_valid(nout_valid), .nout_has_data(nout_has_data), .nout_credit(nout_credit)
);

// File: tb/e2e_credit_ni_tb_top.sv
module e2e_credit_ni_tb_top;
  localparam int N = 2;
  localparam int W = 16;
  localparam int DEPTH = 8;
  localparam int CRW = 5;
  localparam int TMO = 16;
  localparam int DELAY = 3;

  // vector: [19:18] tx mask, [17:16] drain mask, [15:8] cycles,
  // [7:4] words expected on conn 0, [3:0] on conn 1 (15 = not checked)
  localparam logic [19:0] VEC [7] = '{
    {2'b11, 2'b00, 8'd30, 4'd8,  4'd8},
    {2'b10, 2'b00, 8'd5,  4'd0,  4'd5},
    {2'b01, 2'b00, 8'd3,  4'd3,  4'd0},
    {2'b11, 2'b00, 8'd10, 4'd8,  4'd2},
    {2'b11, 2'b11, 8'd60, 4'd15, 4'd15},
    {2'b01, 2'b01, 8'd40, 4'd15, 4'd0},
    {2'b10, 2'b10, 8'd40, 4'd0,  4'd15}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] tx_valid = '0, tx_is_req = '0, tx_ready, rx_valid, rx_pop = '0;
  logic [N*W-1:0] tx_data = '0, rx_data;
  logic [N*4-1:0] tx_rsp_len = '0;
  logic nout_valid, nout_has_data;
  logic [0:0] nout_conn;
  logic [W-1:0] nout_data;
  logic [CRW-1:0] nout_credit;
  logic nin_valid, nin_has_data;
  logic [0:0] nin_conn;
  logic [W-1:0] nin_data;
  logic [CRW-1:0] nin_credit;

  always #10 clk = ~clk;

  e2e_credit_ni #(.NCONN(N), .W(W), .DEPTH(DEPTH), .CRW(CRW), .TMO(TMO)) dut_i (
    .clk(clk), .rst(rst),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_is_req(tx_is_req),
    .tx_rsp_len(tx_rsp_len), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_pop(rx_pop),
    .nout_valid(nout_valid), .nout_conn(nout_conn), .nout_has_data(nout_has_data),
    .nout_data(nout_data), .nout_credit(nout_credit),
    .nin_valid(nin_valid), .nin_conn(nin_conn), .nin_has_data(nin_has_data),
    .nin_data(nin_data), .nin_credit(nin_credit)
  );

  // loopback channel: lossless, in order, fixed delay
  logic dv [DELAY], dh [DELAY];
  logic [0:0] dc [DELAY];
  logic [W-1:0] dd [DELAY];
  logic [CRW-1:0] dk [DELAY];
  always @(posedge clk) begin
    for (int s = DELAY - 1; s > 0; s--) begin
      dv[s] <= dv[s-1]; dh[s] <= dh[s-1]; dc[s] <= dc[s-1];
      dd[s] <= dd[s-1]; dk[s] <= dk[s-1];
    end
    dv[0] <= nout_valid; dh[0] <= nout_has_data; dc[0] <= nout_conn;
    dd[0] <= nout_data;  dk[0] <= nout_credit;
    if (rst) for (int s = 0; s < DELAY; s++) dv[s] <= 1'b0;
  end
  assign nin_valid = dv[DELAY-1];
  assign nin_has_data = dh[DELAY-1];
  assign nin_conn = dc[DELAY-1];
  assign nin_data = dd[DELAY-1];
  assign nin_credit = dk[DELAY-1];

  int total = 0, fails = 0, cyc = 0;
  int seq [N], acc [N], occ_b [N], co_cnt [N], co_cred [N], co_cyc [N], dat_cred [N];
  logic [N-1:0] last_ready;
  logic [W-1:0] sq0 [$];
  logic [W-1:0] sq1 [$];

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (!rst && nout_valid) begin
      if (!nout_has_data) begin
        co_cnt[nout_conn]++;
        co_cred[nout_conn] = nout_credit;
        co_cyc[nout_conn] = cyc;
      end else begin
        dat_cred[nout_conn] = nout_credit;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] txv, input logic [N-1:0] req,
                      input logic [3:0] len1, input logic [N-1:0] pop);
    logic [W-1:0] e;
    @(negedge clk);
    tx_valid = txv;
    tx_is_req = req;
    tx_rsp_len = {len1, 4'd0};
    for (int i = 0; i < N; i++) tx_data[i*W +: W] = {4'(i), 12'(seq[i])};
    rx_pop = pop;
    #1;
    last_ready = tx_ready;
    for (int i = 0; i < N; i++) begin
      if (tx_valid[i] && tx_ready[i]) begin
        if (i == 0) sq0.push_back(tx_data[i*W +: W]);
        else sq1.push_back(tx_data[i*W +: W]);
        seq[i]++;
        acc[i]++;
      end
    end
    if (nin_valid && nin_has_data) begin
      occ_b[nin_conn] = occ_b[nin_conn] + 1 - ((rx_pop[nin_conn] && rx_valid[nin_conn]) ? 1 : 0);
      chk(occ_b[nin_conn] <= DEPTH, "R3 no overflow", occ_b[nin_conn], DEPTH);
    end
    for (int i = 0; i < N; i++) begin
      if (pop[i] && rx_valid[i]) begin
        if (!(nin_valid && nin_has_data && nin_conn == 1'(i))) occ_b[i]--;
        if ((i == 0 && sq0.size() == 0) || (i == 1 && sq1.size() == 0)) begin
          chk(1'b0, "R3 unexpected word", int'(rx_data[i*W +: W]), -1);
        end else begin
          e = (i == 0) ? sq0.pop_front() : sq1.pop_front();
          chk(rx_data[i*W +: W] == e, "R3 order", int'(rx_data[i*W +: W]), int'(e));
        end
      end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) step('0, '0, 4'd0, '0);
  endtask

  task automatic drain_all();
    repeat (30) step('0, '0, 4'd0, 2'b11);
    idle(40);
    chk(sq0.size() == 0 && sq1.size() == 0, "R5 all delivered",
        sq0.size() + sq1.size(), 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (int'(120000)) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    int a0, a1, c0, pc;
    for (int i = 0; i < N; i++) begin
      seq[i] = 0; acc[i] = 0; occ_b[i] = 0;
      co_cnt[i] = 0; co_cred[i] = 0; co_cyc[i] = 0; dat_cred[i] = 0;
    end
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R2: idle outputs after reset
    chk(nout_valid == 1'b0, "R2 nout_valid", nout_valid, 0);
    chk(rx_valid == '0, "R2 rx_valid", rx_valid, 0);
    chk(tx_ready == '0, "R2 tx_ready", tx_ready, 0);

    // vector table: each entry starts from a drained, credit-complete state
    for (int v = 0; v < 7; v++) begin
      a0 = acc[0];
      a1 = acc[1];
      repeat (int'(VEC[v][15:8])) step(VEC[v][19:18], '0, 4'd0, VEC[v][17:16]);
      if (VEC[v][7:4] != 4'd15)
        chk(acc[0] - a0 == int'(VEC[v][7:4]), "R1 R2 accepted conn0", acc[0] - a0, int'(VEC[v][7:4]));
      if (VEC[v][3:0] != 4'd15)
        chk(acc[1] - a1 == int'(VEC[v][3:0]), "R1 R2 accepted conn1", acc[1] - a1, int'(VEC[v][3:0]));
      if (v == 0)
        chk(last_ready == '0, "R1 blocked at zero space", last_ready, 0);
      drain_all();
    end

    // R8: single pending credit goes home after the timeout
    step(2'b01, '0, 4'd0, '0);
    idle(DELAY + 3);
    c0 = co_cnt[0];
    step('0, '0, 4'd0, 2'b01);
    pc = cyc;
    idle(TMO + 8);
    chk(co_cnt[0] == c0 + 1, "R8 timeout credit flit", co_cnt[0] - c0, 1);
    chk(co_cred[0] == 1, "R8 timeout credit value", co_cred[0], 1);
    chk(co_cyc[0] - pc >= TMO + 1 && co_cyc[0] - pc <= TMO + 3, "R8 timeout delay",
        co_cyc[0] - pc, TMO + 2);
    drain_all();

    // R7 and R4: half a buffer of drains triggers a credit-only flit at once
    repeat (DEPTH / 2) step(2'b01, '0, 4'd0, '0);
    idle(DELAY + 4);
    c0 = co_cnt[0];
    repeat (DEPTH / 2) step('0, '0, 4'd0, 2'b01);
    pc = cyc;
    idle(6);
    chk(co_cnt[0] == c0 + 1, "R7 threshold credit flit", co_cnt[0] - c0, 1);
    chk(co_cred[0] == DEPTH / 2, "R4 one credit per drained word", co_cred[0], DEPTH / 2);
    chk(co_cyc[0] - pc >= 1 && co_cyc[0] - pc <= 3, "R7 threshold delay", co_cyc[0] - pc, 2);
    drain_all();

    // R6: pending credit rides on the next data word of the same connection
    step(2'b10, '0, 4'd0, '0);
    idle(DELAY + 3);
    c0 = co_cnt[1];
    step('0, '0, 4'd0, 2'b10);
    step(2'b10, '0, 4'd0, '0);
    idle(3);
    chk(dat_cred[1] == 1, "R6 piggybacked credit", dat_cred[1], 1);
    chk(co_cnt[1] == c0, "R6 no credit-only flit", co_cnt[1] - c0, 0);
    drain_all();

    // R9: response room held back before a request is issued
    step(2'b10, 2'b10, 4'd8, '0);
    chk(last_ready[1] == 1'b1, "R9 full-room request accepted", last_ready[1], 1);
    step(2'b10, 2'b10, 4'd1, '0);
    chk(last_ready[1] == 1'b0, "R9 request blocked by held room", last_ready[1], 0);
    repeat (DELAY + 3) step(2'b10, 2'b10, 4'd1, '0);
    chk(last_ready[1] == 1'b0, "R9 still blocked after arrival", last_ready[1], 0);
    step(2'b10, 2'b10, 4'd1, 2'b10);
    step(2'b10, 2'b10, 4'd1, '0);
    chk(last_ready[1] == 1'b1, "R9 accepted after drain", last_ready[1], 1);
    drain_all();

    summary();
    $finish;
  end

endmodule